// File: doc/BRIEF.md
# Seven-State Mealy Sequence Controller

This block is a synchronous Mealy controller with seven named states: an initial state INIT and six working states W2 through W7. A single serial bit `x` is sampled on each rising clock edge and moves the machine along a fixed, irregular transition table. The 2-bit output `y` is a function of both the current state and the present value of `x`, so it follows `x` within the same cycle.

The parameter `ENC` chooses how the state is held in flip-flops, and nothing else changes. Value 0 gives a dense 3-bit binary code. Value 1 gives one flip-flop per state. Value 2 gives a grouped 3-bit code. In the grouped code, the states that share a next state and an output under `x = 0` lie on one face of the code cube, so a single product term recognises them.

Every encoding presents the current state on `state_onehot` in the same decoded form. Instances built with different encodings can therefore be compared edge for edge. A 3-bit code with no state assigned, or a one-hot vector that is not exactly one-hot, returns to INIT on the next edge.

Top module: `mealy7_ctrl`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high, the state does not change before the next rising edge. After that edge the state is INIT, in every encoding.
- R2: With `x = 0`, INIT goes to W6, and W2 and W3 go to W5. W4 goes to W6. Each of these four transitions drives `y = 2'b00`.
- R3: With `x = 0`, W5 goes to INIT with `y = 2'b10`, W6 goes to INIT with `y = 2'b01`, and W7 goes to W5 with `y = 2'b00`.
- R4: With `x = 1`, INIT goes to W4 with `y = 2'b01`. W2 goes to W3, W3 goes to W7 and W4 goes to W6, each with `y = 2'b10`.
- R5: With `x = 1`, W5 and W6 both go to W2, and W7 goes to W6. All three drive `y = 2'b00`.
- R6: `y` is combinational in `x` and the current state. A change of `x` between edges changes `y` in the same cycle to the table value for the new `x`.
- R7: `state_onehot` has exactly one bit set at all times after the first reset. Bit 0 is INIT, and bits 1 to 6 are W2 to W7 in that order.
- R8: The instances built with `ENC` = 0, 1 and 2 produce identical `y` and `state_onehot` for identical input streams.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to INIT |
| x | input | 1 | Serial control bit, sampled at each edge |
| y | output | 2 | Mealy output for the current state and `x` |
| state_onehot | output | 7 | Decoded current state, bit 0 = INIT, bit k = W(k+1) |

## Verification
The output `y` is due in the same cycle as `x`. The bench therefore drives `x` after the falling edge and samples `y` one time unit later, with no clock edge in between. In each cycle it first applies the opposite value of `x` and then the final value, so the same-cycle response is checked for both values. A state transition, or a reset, appears on `state_onehot` one edge after the value of `x` or `rst` it was sampled with. The reference state advances only after that rising edge, and the next comparison happens at the following falling edge. In a cycle where `rst` is high, the bench also confirms before the edge that the state has not yet moved.

// File: rtl/mealy7_pkg.sv
package mealy7_pkg;

    localparam int NUM_STATES = 7;
    localparam int CODE_W     = $clog2(NUM_STATES);
    localparam int OUT_W      = 2;

    localparam int ENC_BINARY  = 0;
    localparam int ENC_ONEHOT  = 1;
    localparam int ENC_GROUPED = 2;

    typedef logic [NUM_STATES-1:0] hot_t;
    typedef logic [CODE_W-1:0]     code_t;

    // symbolic state index: also the bit position in the decoded vector
    typedef enum logic [CODE_W-1:0] {
        SYM_INIT = 3'd0,
        SYM_W2   = 3'd1,
        SYM_W3   = 3'd2,
        SYM_W4   = 3'd3,
        SYM_W5   = 3'd4,
        SYM_W6   = 3'd5,
        SYM_W7   = 3'd6
    } sym_e;

    localparam int IX_INIT = int'(SYM_INIT);
    localparam int IX_W2   = int'(SYM_W2);
    localparam int IX_W3   = int'(SYM_W3);
    localparam int IX_W4   = int'(SYM_W4);
    localparam int IX_W5   = int'(SYM_W5);
    localparam int IX_W6   = int'(SYM_W6);
    localparam int IX_W7   = int'(SYM_W7);

    // grouped code: W2/W3/W7 on face 1xx, W5/W6 on face 01x
    localparam code_t GC_INIT = 3'b000;
    localparam code_t GC_W4   = 3'b001;
    localparam code_t GC_W5   = 3'b010;
    localparam code_t GC_W6   = 3'b011;
    localparam code_t GC_W2   = 3'b100;
    localparam code_t GC_W3   = 3'b101;
    localparam code_t GC_W7   = 3'b110;
    localparam code_t GC_FREE = 3'b111;

    typedef struct packed {
        logic hi;
        logic lo;
    } out_t;

    // dense binary next-state function; any unassigned code maps to INIT
    function automatic code_t dense_next(code_t cur, logic x);
        sym_e n;
        case (cur)
            SYM_INIT: n = x ? SYM_W4 : SYM_W6;
            SYM_W2:   n = x ? SYM_W3 : SYM_W5;
            SYM_W3:   n = x ? SYM_W7 : SYM_W5;
            SYM_W4:   n = SYM_W6;
            SYM_W5:   n = x ? SYM_W2 : SYM_INIT;
            SYM_W6:   n = x ? SYM_W2 : SYM_INIT;
            SYM_W7:   n = x ? SYM_W6 : SYM_W5;
            default:  n = SYM_INIT;
        endcase
        return code_t'(n);
    endfunction

endpackage

// File: rtl/mealy7_dense_store.sv
module mealy7_dense_store
    import mealy7_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x,
    output hot_t cur_hot
);
    code_t q;
    code_t d;

    always_comb d = dense_next(q, x);

    always_ff @(posedge clk) begin
        if (rst) q <= code_t'(SYM_INIT);
        else     q <= d;
    end

    for (genvar k = 0; k < NUM_STATES; k++) begin : g_dec
        assign cur_hot[k] = (q == code_t'(k));
    end
endmodule

// File: rtl/mealy7_hot_store.sv
module mealy7_hot_store
    import mealy7_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x,
    output hot_t cur_hot
);
    hot_t q;
    hot_t d;
    logic legal;

    assign legal = ($countones(q) == 1);

    // each bit is driven only by its predecessor bits and x
    always_comb begin
        d          = '0;
        d[IX_INIT] = ~x & (q[IX_W5] | q[IX_W6]);
        d[IX_W2]   =  x & (q[IX_W5] | q[IX_W6]);
        d[IX_W3]   =  x & q[IX_W2];
        d[IX_W4]   =  x & q[IX_INIT];
        d[IX_W5]   = ~x & (q[IX_W2] | q[IX_W3] | q[IX_W7]);
        d[IX_W6]   = q[IX_W4] | (~x & q[IX_INIT]) | (x & q[IX_W7]);
        d[IX_W7]   =  x & q[IX_W3];
        if (!legal) d = hot_t'(1) << IX_INIT;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= hot_t'(1) << IX_INIT;
        else     q <= d;
    end

    assign cur_hot = legal ? q : '0;
endmodule

// File: rtl/mealy7_group_store.sv
module mealy7_group_store
    import mealy7_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x,
    output hot_t cur_hot
);
    code_t q;
    code_t d;
    logic  on_w2_face;   // W2, W3, W7 (plus free code)
    logic  on_w5_face;   // W5, W6

    assign on_w2_face = q[2];
    assign on_w5_face = ~q[2] & q[1];

    always_comb begin
        if (q == GC_FREE)               d = GC_INIT;
        else if (on_w2_face && !x)      d = GC_W5;
        else if (on_w5_face)            d = x ? GC_W2 : GC_INIT;
        else begin
            case (q)
                GC_INIT: d = x ? GC_W4 : GC_W6;
                GC_W4:   d = GC_W6;
                GC_W2:   d = GC_W3;
                GC_W3:   d = GC_W7;
                GC_W7:   d = GC_W6;
                default: d = GC_INIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= GC_INIT;
        else     q <= d;
    end

    always_comb begin
        cur_hot = '0;
        case (q)
            GC_INIT: cur_hot[IX_INIT] = 1'b1;
            GC_W2:   cur_hot[IX_W2]   = 1'b1;
            GC_W3:   cur_hot[IX_W3]   = 1'b1;
            GC_W4:   cur_hot[IX_W4]   = 1'b1;
            GC_W5:   cur_hot[IX_W5]   = 1'b1;
            GC_W6:   cur_hot[IX_W6]   = 1'b1;
            GC_W7:   cur_hot[IX_W7]   = 1'b1;
            default: cur_hot = '0;
        endcase
    end
endmodule

// File: rtl/mealy7_outmap.sv
module mealy7_outmap
    import mealy7_pkg::*;
(
    input  hot_t       cur_hot,
    input  logic       x,
    output logic [1:0] y
);
    out_t o;

    always_comb begin
        o.hi = x ? (cur_hot[IX_W2] | cur_hot[IX_W3] | cur_hot[IX_W4]) : cur_hot[IX_W5];
        o.lo = x ?  cur_hot[IX_INIT]                                : cur_hot[IX_W6];
    end

    assign y = o;
endmodule

// File: rtl/mealy7_ctrl.sv
module mealy7_ctrl
    import mealy7_pkg::*;
#(
    parameter int ENC = ENC_BINARY
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       x,
    output logic [1:0] y,
    output logic [6:0] state_onehot
);
    hot_t cur_hot;

    if (ENC == ENC_ONEHOT) begin : g_hot
        mealy7_hot_store u_store (.clk(clk), .rst(rst), .x(x), .cur_hot(cur_hot));
    end else if (ENC == ENC_GROUPED) begin : g_grp
        mealy7_group_store u_store (.clk(clk), .rst(rst), .x(x), .cur_hot(cur_hot));
    end else begin : g_bin
        mealy7_dense_store u_store (.clk(clk), .rst(rst), .x(x), .cur_hot(cur_hot));
    end

    mealy7_outmap u_out (.cur_hot(cur_hot), .x(x), .y(y));

    assign state_onehot = cur_hot;
endmodule

// File: rtl/mealy7_ctrl_chk.sv
module mealy7_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       x,
    input logic [1:0] y,
    input logic [6:0] state_onehot
);
    logic armed = 1'b0;
    always_ff @(posedge clk) if (rst) armed <= 1'b1;

    assert_reset_init_R1: assert property (@(posedge clk)
        rst |=> state_onehot == 7'b000_0001);

    assert_init_zero_R2: assert property (@(posedge clk) disable iff (rst || !armed)
        (state_onehot[0] && !x) |=> state_onehot[5]);

    assert_w5_out_R3: assert property (@(posedge clk) disable iff (rst || !armed)
        (state_onehot[4] && !x) |-> y == 2'b10);

    assert_w4_next_R4: assert property (@(posedge clk) disable iff (rst || !armed)
        state_onehot[3] |=> state_onehot[5]);

    assert_w7_one_R5: assert property (@(posedge clk) disable iff (rst || !armed)
        (state_onehot[6] && x) |-> (y == 2'b00) ##1 state_onehot[5]);

    assert_single_bit_R7: assert property (@(posedge clk) disable iff (rst || !armed)
        $countones(state_onehot) == 1);
endmodule

bind mealy7_ctrl mealy7_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .x(x), .y(y), .state_onehot(state_onehot)
);

// File: tb/sim_mealy7_ctrl.sv
module sim_mealy7_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x   = 1'b0;
    logic [1:0] y0, y1, y2;
    logic [6:0] h0, h1, h2;

    int total = 0;
    int bad   = 0;
    int ref_s = 0;
    bit known = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mealy7_ctrl #(.ENC(0)) u0 (.clk(clk), .rst(rst), .x(x), .y(y0), .state_onehot(h0));
    mealy7_ctrl #(.ENC(1)) u1 (.clk(clk), .rst(rst), .x(x), .y(y1), .state_onehot(h1));
    mealy7_ctrl #(.ENC(2)) u2 (.clk(clk), .rst(rst), .x(x), .y(y2), .state_onehot(h2));

    // index 0 INIT, 1..6 W2..W7
    function automatic int ref_next(int s, logic xv);
        case (s)
            0: return xv ? 3 : 5;
            1: return xv ? 2 : 4;
            2: return xv ? 6 : 4;
            3: return 5;
            4: return xv ? 1 : 0;
            5: return xv ? 1 : 0;
            default: return xv ? 5 : 4;
        endcase
    endfunction

    function automatic logic [1:0] ref_y(int s, logic xv);
        if (xv) return (s == 0) ? 2'b01 : (s >= 1 && s <= 3) ? 2'b10 : 2'b00;
        return (s == 4) ? 2'b10 : (s == 5) ? 2'b01 : 2'b00;
    endfunction

    function automatic string tag_of(int s, logic xv);
        if (!xv) return (s <= 3) ? "R2" : "R3";
        return (s <= 3) ? "R4" : "R5";
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input logic xv);
        logic [6:0] eh;
        logic [1:0] ey;
        string t;
        eh = 7'd1 << ref_s;
        ey = ref_y(ref_s, xv);
        t  = tag_of(ref_s, xv);
        chk(y0 == ey, t, y0, ey);
        chk(y1 == ey, t, y1, ey);
        chk(y2 == ey, t, y2, ey);
        chk(h0 == eh, t, h0, eh);
        chk($countones(h1) == 1, "R7", h1, eh);
        chk(h2 == eh, "R7", h2, eh);
        chk(h0 == h1 && h1 == h2 && y0 == y1 && y1 == y2, "R8",
            {h0, h1, h2}, {eh, eh, eh});
    endtask

    task automatic step(input logic xv, input logic rv);
        @(negedge clk);
        rst = rv;
        if (known) begin
            x = ~xv; #1;
            chk(y0 == ref_y(ref_s, ~xv) && y1 == y0 && y2 == y0, "R6",
                y0, ref_y(ref_s, ~xv));
        end
        x = xv; #1;
        if (known) begin
            check_all(xv);
            if (rv) chk(h0 == (7'd1 << ref_s), "R1", h0, 7'd1 << ref_s);
        end
        @(posedge clk);
        #1;
        if (rv) begin
            ref_s = 0;
            known = 1;
            chk(h0 == 7'd1 && h1 == 7'd1 && h2 == 7'd1, "R1", {h0, h1, h2}, {7'd1, 7'd1, 7'd1});
        end else if (known) begin
            ref_s = ref_next(ref_s, xv);
        end
    endtask

    initial begin
        void'($urandom(32'h1F2E_3D4C));
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        // directed walk: INIT-1->W4->W6-1->W2-1->W3-1->W7-0->W5-0->INIT
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0);
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        // reset from a working state
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        for (int i = 0; i < N_RANDOM; i++) begin
            step(1'($urandom % 2), ($urandom % 64) == 0);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule